// File: doc/BRIEF.md
# Two-Bank SDRAM Command Controller

This block turns single-beat host requests into the command sequence a two-bank SDR SDRAM needs. The device has 11-bit rows, 9-bit columns and an 8-bit data bus. The host offers a request by holding `req_valid` together with a write flag, a 21-bit address and write data. The controller answers with `req_ready` for one cycle, in the cycle it issues the matching read or write command. It keeps one open row per bank. A row hit goes straight to the column command. A row miss first closes the open row with a precharge and then opens the new row with an activate.

After reset the controller drives no-operation commands for a programmable settling time. It then runs a fixed start-up sequence: precharge of both banks, one auto refresh, and a mode register write. After that it accepts requests. A free-running interval counter raises periodic refresh requests. When a refresh is due, the controller stops accepting host work, closes both banks and issues the refresh. A per-bank age counter closes any row that has been open too long.

Every spacing rule is a parameter in clock cycles and is enforced by per-bank down-counters. The defaults suit a 100 MHz clock.

Command pins are registered: a command chosen in cycle t is on the pins in cycle t+1. The clock enable is held high whenever reset is not asserted.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted, `sd_cs_n` is 1 and `sd_cke` is 0. From the first clock edge after reset is released, `sd_cke` is 1 and stays 1.
- R2: With `sd_cs_n` low, the code {`sd_ras_n`,`sd_cas_n`,`sd_we_n`} is one of the following and never any other value: 000 mode write, 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 111 no-operation.
- R3: After INIT_CYCLES cycles of no-operation, the first three commands are, in this order: a precharge with A10=1, an auto refresh, and a mode write with `sd_a`=MODE_WORD and `sd_ba`=0. No read or write is issued before then.
- R4: The request address is split as bank = bit 20, row = bits 19:9, column = bits 8:0. An activate puts the row on `sd_a` and the bank on `sd_ba`. A read or write puts the column on `sd_a[8:0]`, with A9=0 and A10=0, so no auto-precharge happens and the row stays open. A precharge with A10=0 closes the bank given by `sd_ba`; a precharge with A10=1 closes both banks.
- R5: `req_ready` is high only while `req_valid` is high. The cycle after `req_ready`, the pins carry a read (write flag 0) or a write (write flag 1) to the requested bank and column, and the row open in that bank equals the requested row. No read or write appears on the pins without a request.
- R6: In the cycle a write is on the pins, `sd_dq_oe`=1 and `sd_dq` equals the write data of the accepted request. On every other command `sd_dq_oe`=0.
- R7: For commands to the same bank, measured in cycles between the two commands on the pins:
  - activate to read or write is at least TRCD;
  - activate to precharge is at least TRAS;
  - activate to activate is at least TRC;
  - precharge to activate is at least TRP;
  - write to precharge is at least TDPL+1.
- R8: Rules across banks and for global commands:
  - Activates to different banks are at least TRRD apart.
  - No command follows a mode write within TMRD cycles.
  - No command follows an auto refresh within TRC cycles.
  - An auto refresh is issued only when both banks are closed and at least TRP cycles have passed since each bank's last precharge.
- R9: After start-up, consecutive auto refreshes are spaced REF_INTERVAL cycles apart, give or take less than 32 cycles.
- R10: A row is never open for more than TRAS_LIMIT cycles. The controller issues the precharge by itself, even when the host sends no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | {bank, row[10:0], column[8:0]} |
| req_wdata | input | 8 | Write data for the request |
| req_ready | output | 1 | Request accepted this cycle |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_a | output | 11 | Multiplexed row/column/flag address |
| sd_dq | output | 8 | Write data toward the SDRAM |
| sd_dq_oe | output | 1 | Write data drive enable |

## Verification
The bench sends long random request streams over three rows in each of both banks. This mixes row hits, row misses in the same bank and alternation between banks. It thereby separates the hit path, the close-then-open path and the cross-bank activate spacing. Directed bursts of same-row hits show that the column command comes out as soon as TRCD allows. A write followed at once by a miss in the same bank shows the write-to-precharge spacing. A single access followed by a long idle period must end in a self-issued precharge within TRAS_LIMIT. Long idle stretches expose the refresh cadence and the close-all step that comes before each refresh.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int TRCD         = 2,
  parameter int TRAS         = 5,
  parameter int TRC          = 7,
  parameter int TRP          = 2,
  parameter int TRRD         = 2,
  parameter int TMRD         = 2,
  parameter int TDPL         = 1,
  parameter int TRAS_LIMIT   = 10000,
  parameter int REF_INTERVAL = 1562,
  parameter int INIT_CYCLES  = 10000,
  parameter logic [ROW_W-1:0] MODE_WORD = 11'h020
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W:0]   req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   sd_cke,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic                   sd_ba,
  output logic [ROW_W-1:0]       sd_a,
  output logic [DATA_W-1:0]      sd_dq,
  output logic                   sd_dq_oe
);
  localparam int TW = $clog2(TRC + TRAS + TRP + TMRD + TDPL + TRCD + TRRD + 2);
  localparam int AW = $clog2(TRAS_LIMIT + 1);
  localparam int RW = $clog2(REF_INTERVAL + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam logic [2:0] C_MRS = 3'b000, C_ACT = 3'b011, C_RD  = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

  typedef enum logic [2:0] {PH_WAIT, PH_PALL, PH_REF, PH_MRS, PH_RUN} phase_t;

  phase_t            phase;
  logic [IW-1:0]     init_cnt;
  logic [RW-1:0]     ref_cnt;
  logic              ref_pend;
  logic [TW-1:0]     gap, rrd_wait;
  logic [1:0]        open_q;
  logic [ROW_W-1:0]  row_q    [2];
  logic [TW-1:0]     act_wait [2];
  logic [TW-1:0]     pre_wait [2];
  logic [TW-1:0]     col_wait [2];
  logic [AW-1:0]     age      [2];

  logic [2:0]        cmd;
  logic              cmd_ba, cmd_all;
  logic [ROW_W-1:0]  cmd_a;

  wire               rb      = req_addr[ROW_W+COL_W];
  wire [ROW_W-1:0]   rrow    = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0]   rcol    = req_addr[COL_W-1:0];
  wire [1:0]         sel_b   = cmd_ba ? 2'b10 : 2'b01;
  wire               idle_ok = (open_q == 2'b00) && (act_wait[0] == '0) &&
                               (act_wait[1] == '0) && (gap == '0);
  wire [1:0]         force_q = {open_q[1] && (age[1] >= AW'(TRAS_LIMIT - 2)),
                                open_q[0] && (age[0] >= AW'(TRAS_LIMIT - 2))};

  function automatic logic [TW-1:0] tick(input logic [TW-1:0] cur, input logic ld, input int val);
    logic [TW-1:0] n;
    n = (cur != '0) ? cur - 1'b1 : '0;
    if (ld && TW'(val) > n) n = TW'(val);
    return n;
  endfunction

  always_comb begin
    cmd = C_NOP; cmd_ba = 1'b0; cmd_all = 1'b0; cmd_a = '0; req_ready = 1'b0;
    case (phase)
      PH_PALL: begin cmd = C_PRE; cmd_all = 1'b1; end
      PH_REF:  if (idle_ok) cmd = C_REF;
      PH_MRS:  if (idle_ok) begin cmd = C_MRS; cmd_a = MODE_WORD; end
      PH_RUN:  if (gap == '0) begin
        if (force_q[0] && pre_wait[0] == '0) cmd = C_PRE;
        else if (force_q[1] && pre_wait[1] == '0) begin cmd = C_PRE; cmd_ba = 1'b1; end
        else if (ref_pend) begin
          if (open_q[0] && pre_wait[0] == '0) cmd = C_PRE;
          else if (open_q[1] && pre_wait[1] == '0) begin cmd = C_PRE; cmd_ba = 1'b1; end
          else if (idle_ok) cmd = C_REF;
        end else if (req_valid) begin
          cmd_ba = rb;
          if (open_q[rb]) begin
            if (row_q[rb] == rrow) begin
              if (col_wait[rb] == '0) begin
                cmd = req_write ? C_WR : C_RD; cmd_a = ROW_W'(rcol); req_ready = 1'b1;
              end
            end else if (pre_wait[rb] == '0) cmd = C_PRE;
          end else if (act_wait[rb] == '0 && rrd_wait == '0) begin
            cmd = C_ACT; cmd_a = rrow;
          end
        end
      end
      default: ;
    endcase
    if (cmd == C_PRE) cmd_a[ROW_W-1] = cmd_all;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_WAIT; init_cnt <= IW'(INIT_CYCLES); ref_cnt <= RW'(REF_INTERVAL - 1);
      ref_pend <= 1'b0; gap <= '0; rrd_wait <= '0; open_q <= 2'b00;
      for (int b = 0; b < 2; b++) begin
        row_q[b] <= '0; act_wait[b] <= '0; pre_wait[b] <= '0; col_wait[b] <= '0; age[b] <= '0;
      end
      sd_cke <= 1'b0; sd_cs_n <= 1'b1; {sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      sd_ba <= 1'b0; sd_a <= '0; sd_dq <= '0; sd_dq_oe <= 1'b0;
    end else begin
      sd_cke <= 1'b1; sd_cs_n <= 1'b0; {sd_ras_n, sd_cas_n, sd_we_n} <= cmd;
      sd_ba <= cmd_ba; sd_a <= cmd_a; sd_dq <= req_wdata; sd_dq_oe <= (cmd == C_WR);

      case (phase)
        PH_WAIT: if (init_cnt == '0) phase <= PH_PALL; else init_cnt <= init_cnt - 1'b1;
        PH_PALL: phase <= PH_REF;
        PH_REF:  if (cmd == C_REF) phase <= PH_MRS;
        PH_MRS:  if (cmd == C_MRS) phase <= PH_RUN;
        default: ;
      endcase

      if (cmd == C_REF) ref_pend <= 1'b0;
      if (phase == PH_RUN) begin
        if (ref_cnt == '0) begin ref_cnt <= RW'(REF_INTERVAL - 1); ref_pend <= 1'b1; end
        else ref_cnt <= ref_cnt - 1'b1;
      end

      gap      <= tick(gap, cmd == C_REF || cmd == C_MRS, (cmd == C_MRS) ? TMRD - 1 : TRC - 1);
      rrd_wait <= tick(rrd_wait, cmd == C_ACT, TRRD - 1);

      for (int b = 0; b < 2; b++) begin
        act_wait[b] <= tick(act_wait[b],
                            (cmd == C_ACT && sel_b[b]) || (cmd == C_PRE && (cmd_all || sel_b[b])) || cmd == C_REF,
                            (cmd == C_PRE) ? TRP - 1 : TRC - 1);
        pre_wait[b] <= tick(pre_wait[b], (cmd == C_ACT || cmd == C_WR) && sel_b[b],
                            (cmd == C_ACT) ? TRAS - 1 : TDPL);
        col_wait[b] <= tick(col_wait[b], cmd == C_ACT && sel_b[b], TRCD - 1);
        if (cmd == C_ACT && sel_b[b]) begin
          open_q[b] <= 1'b1; row_q[b] <= cmd_a; age[b] <= '0;
        end else begin
          if (cmd == C_PRE && (cmd_all || sel_b[b])) open_q[b] <= 1'b0;
          if (open_q[b] && age[b] != AW'(TRAS_LIMIT)) age[b] <= age[b] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int TRRD   = 2,
  parameter int TMRD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_ready,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [DATA_W-1:0] sd_dq,
  input logic              sd_dq_oe
);
  wire [2:0] code    = {sd_ras_n, sd_cas_n, sd_we_n};
  wire       is_cmd  = !sd_cs_n && code != 3'b111;
  wire       is_act  = !sd_cs_n && code == 3'b011;
  wire       is_mrs  = !sd_cs_n && code == 3'b000;
  logic [15:0] since_act, since_mrs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 16'hFFFF; since_mrs <= 16'hFFFF;
    end else begin
      since_act <= is_act ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 16'd1);
      since_mrs <= is_mrs ? 16'd1 : (since_mrs == 16'hFFFF ? since_mrs : since_mrs + 16'd1);
    end
  end

  p_cke_on_r1: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> sd_cke);
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n) !sd_cs_n |-> code != 3'b110);
  p_ready_valid_r5: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> req_valid);
  p_ready_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!sd_cs_n && sd_ras_n && !sd_cas_n && (sd_we_n == !$past(req_write))));
  p_wdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_write |=> sd_dq_oe && sd_dq == $past(req_wdata));
  p_rrd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> since_act >= 16'(TRRD));
  p_mrd_gap_r8: assert property (@(posedge clk) disable iff (!rst_n) is_cmd |-> since_mrs >= 16'(TMRD));
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.DATA_W(DATA_W), .TRRD(TRRD), .TMRD(TMRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .req_ready(req_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq(sd_dq),
  .sd_dq_oe(sd_dq_oe)
);

// File: tb/tb_sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_cmd_ctrl;
  localparam int TRCD = 2, TRAS = 5, TRC = 7, TRP = 2, TRRD = 2, TMRD = 2, TDPL = 1;
  localparam int TLIM = 60, REFI = 300, INITC = 16;
  localparam logic [10:0] MODE = 11'h020;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [20:0] req_addr = '0;
  logic [7:0] req_wdata = '0, sd_dq;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
  logic [10:0] sd_a;

  sdram_cmd_ctrl #(.TRCD(TRCD), .TRAS(TRAS), .TRC(TRC), .TRP(TRP), .TRRD(TRRD), .TMRD(TMRD),
    .TDPL(TDPL), .TRAS_LIMIT(TLIM), .REF_INTERVAL(REFI), .INIT_CYCLES(INITC), .MODE_WORD(MODE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe));

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  int last_act[2] = '{-1000, -1000}, last_pre[2] = '{-1000, -1000}, last_wr[2] = '{-1000, -1000};
  int last_ref = -1000, last_mrs = -1000, ref_n = 0, init_idx = 0;
  bit m_open[2] = '{0, 0};
  int m_row[2] = '{0, 0};
  bit pend_v = 1'b0, pend_wr = 1'b0, pend_bank = 1'b0;
  int pend_row = 0, pend_col = 0, pend_data = 0;

  function automatic bit f_bank(input logic [20:0] a); return a[20]; endfunction
  function automatic int f_row(input logic [20:0] a); return int'(a[19:9]); endfunction
  function automatic int f_col(input logic [20:0] a); return int'(a[8:0]); endfunction
  function automatic logic [2:0] f_init_code(input int idx);
    return (idx == 0) ? 3'b010 : (idx == 1) ? 3'b001 : 3'b000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] code;
      int b;
      cyc++;
      code = {sd_ras_n, sd_cas_n, sd_we_n};
      b = int'(sd_ba);
      for (int k = 0; k < 2; k++)
        if (m_open[k] && cyc - last_act[k] > TLIM) chk(0, "R10", "row open too long", cyc - last_act[k], TLIM);
      if (pend_v) begin
        chk(!sd_cs_n && (code == 3'b101 || code == 3'b100), "R5", "column command after ready", code, pend_wr ? 4 : 5);
      end
      if (!sd_cs_n && code != 3'b111) begin
        chk(sd_cke, "R1", "cke during command", sd_cke, 1);
        chk(cyc - last_mrs >= TMRD, "R8", "gap after mode write", cyc - last_mrs, TMRD);
        chk(cyc - last_ref >= TRC, "R8", "gap after refresh", cyc - last_ref, TRC);
        if (code != 3'b100) chk(!sd_dq_oe, "R6", "data drive off", sd_dq_oe, 0);
        if (init_idx < 3) begin
          chk(code == f_init_code(init_idx), "R3", "start-up order", code, f_init_code(init_idx));
          if (init_idx == 0) chk(sd_a[10], "R3", "precharge-all flag", sd_a[10], 1);
          init_idx++;
        end
        case (code)
          3'b011: begin
            chk(!m_open[b], "R7", "activate on open bank", m_open[b], 0);
            chk(cyc - last_act[b] >= TRC, "R7", "act-act same bank", cyc - last_act[b], TRC);
            chk(cyc - last_pre[b] >= TRP, "R7", "pre-act", cyc - last_pre[b], TRP);
            chk(cyc - last_act[1-b] >= TRRD, "R8", "act-act other bank", cyc - last_act[1-b], TRRD);
            m_open[b] = 1'b1; m_row[b] = int'(sd_a); last_act[b] = cyc;
          end
          3'b101, 3'b100: begin
            chk(pend_v, "R5", "unrequested column command", pend_v, 1);
            chk(init_idx >= 3, "R3", "column command before start-up", init_idx, 3);
            chk(m_open[b], "R5", "column to closed bank", m_open[b], 1);
            chk(cyc - last_act[b] >= TRCD, "R7", "act-column", cyc - last_act[b], TRCD);
            chk(sd_a[10:9] == 2'b00, "R4", "column flags", sd_a[10:9], 0);
            if (pend_v) begin
              chk(sd_ba == pend_bank, "R4", "column bank", sd_ba, pend_bank);
              chk(int'(sd_a[8:0]) == pend_col, "R4", "column address", sd_a[8:0], pend_col);
              chk(m_row[b] == pend_row, "R5", "open row", m_row[b], pend_row);
              chk((code == 3'b100) == pend_wr, "R5", "read/write kind", code, pend_wr ? 4 : 5);
            end
            if (code == 3'b100) begin
              chk(sd_dq_oe && int'(sd_dq) == pend_data, "R6", "write data", sd_dq, pend_data);
              last_wr[b] = cyc;
            end
          end
          3'b010: begin
            for (int k = 0; k < 2; k++) begin
              if (sd_a[10] || k == b) begin
                chk(cyc - last_act[k] >= TRAS, "R7", "act-pre", cyc - last_act[k], TRAS);
                chk(cyc - last_wr[k] >= TDPL + 1, "R7", "write-pre", cyc - last_wr[k], TDPL + 1);
                if (m_open[k]) chk(cyc - last_act[k] <= TLIM, "R10", "open time at close", cyc - last_act[k], TLIM);
                m_open[k] = 1'b0; last_pre[k] = cyc;
              end
            end
          end
          3'b001: begin
            chk(!m_open[0] && !m_open[1], "R8", "refresh with open bank", {m_open[1], m_open[0]}, 0);
            for (int k = 0; k < 2; k++)
              chk(cyc - last_pre[k] >= TRP, "R8", "pre-refresh", cyc - last_pre[k], TRP);
            ref_n++;
            if (ref_n >= 3)
              chk((cyc - last_ref > REFI - 32) && (cyc - last_ref < REFI + 32), "R9", "refresh spacing", cyc - last_ref, REFI);
            last_ref = cyc;
          end
          3'b000: begin
            chk(sd_a == MODE && sd_ba == 1'b0, "R3", "mode word", sd_a, MODE);
            last_mrs = cyc;
          end
          default: chk(0, "R2", "illegal command code", code, 7);
        endcase
      end
      pend_v = 1'b0;
    end
  end

  task automatic send(input bit wr, input logic [20:0] addr, input logic [7:0] d);
    int waitc = 0;
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #2;
      waitc++;
      if (waitc > 400) begin
        chk(0, "R5", "request stalled", waitc, 400);
        req_valid = 1'b0;
        return;
      end
    end
    pend_v = 1'b1; pend_wr = wr; pend_bank = f_bank(addr);
    pend_row = f_row(addr); pend_col = f_col(addr); pend_data = int'(d);
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  function automatic logic [20:0] mk(input bit bank, input int row, input int col);
    return {bank, 11'(row), 9'(col)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sd_cs_n == 1'b1 && sd_cke == 1'b0, "R1", "reset pins", {sd_cs_n, sd_cke}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd_cke == 1'b1, "R1", "cke after reset", sd_cke, 1);

    for (int i = 0; i < 8; i++) send(i[0], mk(0, 7, i * 3), 8'(i + 8'h40));
    for (int i = 0; i < 8; i++) send(1'b1, mk(i[0], 20 + i, i), 8'(8'hA0 + i));
    for (int i = 0; i < 6; i++) send(1'b0, mk(1, 100 + i, 5), 8'h00);
    for (int i = 0; i < 6; i++) begin
      send(1'b1, mk(0, 30, i), 8'(8'h55 ^ i));
      send(1'b1, mk(0, 31, i), 8'(8'hAA ^ i));
    end

    send(1'b0, mk(1, 9, 17), 8'h00);
    repeat (150) @(negedge clk);
    chk(!m_open[1], "R10", "idle row closed", m_open[1], 0);

    repeat (700) @(negedge clk);
    chk(ref_n >= 4, "R9", "refreshes while idle", ref_n, 4);

    for (int i = 0; i < 2500; i++) begin
      bit wr;
      logic [20:0] a;
      wr = 1'($urandom % 2);
      a = mk(1'($urandom % 2), int'($urandom % 3), int'($urandom % 512));
      send(wr, a, 8'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule